// File: doc/BRIEF.md
# Bit-Field I/O Vector Merge Unit

This block sits beside the datapath of a byte-wide controller that talks to the outside world through two 8-bit I/O banks, a left bank and a right bank. Each bank is reached through a port address. An instruction can name a bit field inside a bank byte, given by a bank select, a position counted from the most significant bit, and a length. The unit does the bit work on that field. A read pulls the field out and right-aligns it. A write drops a new value into the field, leaves every other bit of the byte alone, and sends the updated byte back out on the port.

On each valid operation the unit drives a combinational read address for the selected bank and takes the byte returned on `port_rdata` as the current bank contents. That byte is latched as the bank image. One clock later the unit shows either the extracted field, or a write strobe carrying the merged byte and its port address. There are three operation kinds: extract, insert of a supplied value, and transmit-immediate insert of the instruction's own 5-bit literal.

Top module: `iov_merge_unit`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, the following outputs are all zero: `field_out`, `port_wr`, `port_waddr`, `port_wdata`, `left_vec` and `right_vec`.
- R2: The length code is `instr[7:5]`. Codes 1 to 7 give that many bits, and code 0 gives a full 8-bit field (mask 0xFF).
- R3: Extract is `op_kind` = 2'b00. The bank is `instr[11]` (1 = right) and the position is `p = instr[10:8]`. On the clock edge after the operation, `field_out` becomes `port_rdata` rotated right by (7 − p) and then masked to its low `length` bits. Bits that wrap around during the rotation are part of the result.
- R4: Insert is `op_kind` = 2'b01. The bank is `instr[3]` and the position is `p = instr[2:0]`. `ins_value` and a mask of `length` ones are both shifted left by (7 − p). Bits shifted past bit 7 are dropped. The merged byte is (`port_rdata` & ~mask) | (value & mask).
- R5: On an insert or transmit, every bit of the merged byte that lies outside the shifted mask equals the same bit of `port_rdata`.
- R6: One cycle after an insert or transmit, `port_wr` is high for exactly one cycle. At the same time `port_wdata` carries the merged byte, and the latch of the selected bank (`left_vec` or `right_vec`) holds the same byte.
- R7: `port_raddr` is combinational and points at the selected bank. For the right bank it is `right_addr` + 2^ADDR_W, and for the left bank it is `left_addr`. `port_waddr` registers the address used by the write.
- R8: Transmit is `op_kind` = 2'b10. It inserts `instr[4:0]`, zero-extended, into the field given by `instr[11]` and `instr[10:8]`. `ins_value` is ignored.
- R9: An extract loads the selected bank latch with `port_rdata`, leaves the other latch unchanged and raises no write. `field_out` changes only on an extract.
- R10: When `op_valid` is low, or `op_kind` is 2'b11, nothing changes: no write is raised, and `field_out` and both latches hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_kind | input | 2 | 00 extract, 01 insert, 10 transmit-immediate, 11 reserved |
| instr | input | 12 | Instruction bits 11:0 carrying bank, position, length and literal fields |
| ins_value | input | 8 | Value for insert |
| left_addr | input | ADDR_W | Left bank address |
| right_addr | input | ADDR_W | Right bank address |
| port_rdata | input | 8 | Byte read back from `port_raddr` |
| port_raddr | output | ADDR_W+1 | Read address of the selected bank |
| port_wr | output | 1 | Write strobe |
| port_waddr | output | ADDR_W+1 | Write address |
| port_wdata | output | 8 | Merged byte |
| field_out | output | 8 | Last extracted field, right-aligned |
| left_vec | output | 8 | Left bank latch |
| right_vec | output | 8 | Right bank latch |

## Verification
The bench aims at four corner cases:
- **Length code 0.** A design that treats code 0 as an empty field returns 0 where a full byte is expected.
- **Extraction wrap.** Position 0 with a length above 1 must pull bits back around from the top of the byte. A plain shift would drop them and give a value that is too small.
- **Insertion truncation.** At low positions the shifted value must lose its upper bits. A rotating insert would instead corrupt low-order bits that should be preserved.
- **Unchanged operations.** The transmit literal must ignore `ins_value`, and a reserved code or an idle cycle must change nothing. A wrong decode would show up as a stray write or a changed latch.

// File: rtl/iov_pkg.sv
package iov_pkg;
   localparam int DATA_W  = 8;
   localparam int POS_W   = $clog2(DATA_W);
   localparam int LEN_W   = POS_W + 1;
   localparam int INSTR_W = 12;
   localparam int IMM_W   = 5;

   // instruction field positions (decoded by neighbouring logic too)
   localparam int SRC_BANK_BIT = 11;
   localparam int SRC_POS_LSB  = 8;
   localparam int LEN_LSB      = 5;
   localparam int DST_BANK_BIT = 3;
   localparam int DST_POS_LSB  = 0;

   typedef enum logic [1:0] {
      IOV_EXTRACT = 2'b00,
      IOV_INSERT  = 2'b01,
      IOV_XMIT    = 2'b10,
      IOV_RSVD    = 2'b11
   } iov_kind_e;

   typedef struct packed {
      logic             bank_right;
      logic [POS_W-1:0] pos;
      logic [LEN_W-1:0] len;
   } iov_field_t;
endpackage

// File: rtl/iov_field_decode.sv
module iov_field_decode
   import iov_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   input  iov_kind_e          kind,
   output iov_field_t         fld,
   output logic [DATA_W-1:0]  imm_val
);
   logic [POS_W-1:0] len_code;

   assign len_code = instr[LEN_LSB +: POS_W];

   always_comb begin
      fld.len = (len_code == '0) ? LEN_W'(DATA_W) : {1'b0, len_code};
      if (kind == IOV_INSERT) begin
         fld.bank_right = instr[DST_BANK_BIT];
         fld.pos        = instr[DST_POS_LSB +: POS_W];
      end else begin
         fld.bank_right = instr[SRC_BANK_BIT];
         fld.pos        = instr[SRC_POS_LSB +: POS_W];
      end
   end

   assign imm_val = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
endmodule

// File: rtl/iov_mask_gen.sv
module iov_mask_gen #(
   parameter int DW = 8,
   parameter int SW = $clog2(DW),
   parameter int LW = SW + 1
) (
   input  logic [LW-1:0] len,
   input  logic [SW-1:0] shamt,
   output logic [DW-1:0] low_mask,
   output logic [DW-1:0] placed_mask
);
   // per-bit compare: a full-width length yields all ones without overflow
   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign low_mask[i] = (LW'(i) < len);
   end

   assign placed_mask = low_mask << shamt;
endmodule

// File: rtl/iov_rotator.sv
module iov_rotator #(
   parameter int DW     = 8,
   parameter int SW     = $clog2(DW),
   parameter bit STAGED = 1'b1
) (
   input  logic [DW-1:0] din,
   input  logic [SW-1:0] amt,
   output logic [DW-1:0] dout
);
   if (STAGED) begin : g_staged
      logic [DW-1:0] stg [0:SW];
      assign stg[0] = din;
      for (genvar s = 0; s < SW; s++) begin : g_stage
         localparam int STEP = 1 << s;
         assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][DW-1:STEP]}
                                  : stg[s];
      end
      assign dout = stg[SW];
   end else begin : g_flat
      logic [2*DW-1:0] dbl;
      assign dbl  = {din, din} >> amt;
      assign dout = dbl[DW-1:0];
   end
endmodule

// File: rtl/iov_merge_unit.sv
module iov_merge_unit
   import iov_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter bit ROT_STAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_kind,
   input  logic [11:0]       instr,
   input  logic [7:0]        ins_value,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic [ADDR_W-1:0] right_addr,
   input  logic [7:0]        port_rdata,
   output logic [ADDR_W:0]   port_raddr,
   output logic              port_wr,
   output logic [ADDR_W:0]   port_waddr,
   output logic [7:0]        port_wdata,
   output logic [7:0]        field_out,
   output logic [7:0]        left_vec,
   output logic [7:0]        right_vec
);
   localparam int PA_W = ADDR_W + 1;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("iov_merge_unit: ADDR_W out of range");
   end
   if (DATA_W != 8 || (1 << POS_W) != DATA_W) begin : g_bad_data
      $error("iov_merge_unit: byte geometry inconsistent");
   end

   iov_kind_e         kind;
   iov_field_t        fld;
   logic [DATA_W-1:0] imm_val;
   logic [POS_W-1:0]  shamt;
   logic [DATA_W-1:0] low_mask, placed_mask;
   logic [DATA_W-1:0] rot_q, field_c;
   logic [DATA_W-1:0] ins_src, placed_val, merged_c;
   logic              do_ext, do_wr;

   assign kind = iov_kind_e'(op_kind);

   iov_field_decode u_dec (
      .instr   (instr),
      .kind    (kind),
      .fld     (fld),
      .imm_val (imm_val)
   );

   // MSB-first position -> LSB-first shift distance
   assign shamt = POS_W'(DATA_W - 1) - fld.pos;

   iov_mask_gen #(.DW(DATA_W), .SW(POS_W), .LW(LEN_W)) u_mask (
      .len         (fld.len),
      .shamt       (shamt),
      .low_mask    (low_mask),
      .placed_mask (placed_mask)
   );

   iov_rotator #(.DW(DATA_W), .SW(POS_W), .STAGED(ROT_STAGED)) u_rot (
      .din  (port_rdata),
      .amt  (shamt),
      .dout (rot_q)
   );

   assign field_c    = rot_q & low_mask;
   assign ins_src    = (kind == IOV_XMIT) ? imm_val : ins_value;
   assign placed_val = ins_src << shamt;
   assign merged_c   = (port_rdata & ~placed_mask) | (placed_val & placed_mask);

   assign port_raddr = fld.bank_right ? (PA_W'(right_addr) + PA_W'(1 << ADDR_W))
                                      : PA_W'(left_addr);

   assign do_ext = op_valid && (kind == IOV_EXTRACT);
   assign do_wr  = op_valid && (kind == IOV_INSERT || kind == IOV_XMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_wr    <= 1'b0;
         port_waddr <= '0;
         port_wdata <= '0;
         field_out  <= '0;
         left_vec   <= '0;
         right_vec  <= '0;
      end else begin
         port_wr <= do_wr;
         if (do_wr) begin
            port_waddr <= port_raddr;
            port_wdata <= merged_c;
         end
         if (do_ext) begin
            field_out <= field_c;
         end
         if (do_ext || do_wr) begin
            if (fld.bank_right) right_vec <= do_wr ? merged_c : port_rdata;
            else                left_vec  <= do_wr ? merged_c : port_rdata;
         end
      end
   end
endmodule

// File: rtl/iov_merge_unit_chk.sv
module iov_merge_unit_chk #(
   parameter int ADDR_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [1:0]      op_kind,
   input logic [2:0]      len_code,
   input logic            port_wr,
   input logic [ADDR_W:0] port_waddr,
   input logic [7:0]      port_wdata,
   input logic [7:0]      field_out,
   input logic [7:0]      left_vec,
   input logic [7:0]      right_vec
);
   AST_WR_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr |-> ($past(op_valid) && ($past(op_kind) == 2'b01 || $past(op_kind) == 2'b10))); // R6

   AST_WR_MATCHES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr |-> ((port_waddr[ADDR_W] ? right_vec : left_vec) == port_wdata)); // R6

   AST_FIELD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_kind) == 2'b00 && $past(len_code) != 3'd0)
         |-> ((field_out >> $past(len_code)) == 8'd0)); // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(op_valid) |-> ($stable(left_vec) && $stable(right_vec) && $stable(field_out) && !port_wr)); // R10

   AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_kind) == 2'b11) |-> (!port_wr && $stable(left_vec) && $stable(right_vec))); // R10
endmodule

bind iov_merge_unit iov_merge_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_kind    (op_kind),
   .len_code   (instr[7:5]),
   .port_wr    (port_wr),
   .port_waddr (port_waddr),
   .port_wdata (port_wdata),
   .field_out  (field_out),
   .left_vec   (left_vec),
   .right_vec  (right_vec)
);

// File: tb/iov_merge_unit_tb_top.sv
`timescale 1ns/1ps
module iov_merge_unit_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op_kind = 2'b00;
   logic [11:0]   instr = '0;
   logic [7:0]    ins_value = '0;
   logic [AW-1:0] left_addr = '0;
   logic [AW-1:0] right_addr = '0;
   logic [7:0]    port_rdata = '0;
   logic [AW:0]   port_raddr;
   logic          port_wr;
   logic [AW:0]   port_waddr;
   logic [7:0]    port_wdata;
   logic [7:0]    field_out;
   logic [7:0]    left_vec;
   logic [7:0]    right_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   int m_field, m_wr, m_waddr, m_wdata, m_left, m_right;

   always #2 clk = ~clk;

   iov_merge_unit #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .instr(instr), .ins_value(ins_value), .left_addr(left_addr),
      .right_addr(right_addr), .port_rdata(port_rdata), .port_raddr(port_raddr),
      .port_wr(port_wr), .port_waddr(port_waddr), .port_wdata(port_wdata),
      .field_out(field_out), .left_vec(left_vec), .right_vec(right_vec)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tf, input string tw, input string ta);
      chk(tf, "field_out", int'(field_out), m_field);
      chk(tw, "port_wr", int'(port_wr), m_wr);
      chk(tw, "port_wdata", int'(port_wdata), m_wdata);
      chk(ta, "port_waddr", int'(port_waddr), m_waddr);
      chk(tw, "left_vec", int'(left_vec), m_left);
      chk(tw, "right_vec", int'(right_vec), m_right);
   endtask

   function automatic logic [11:0] mk(input int sb, input int sp, input int ln,
                                      input int db, input int dp);
      return 12'((sb << 11) | (sp << 8) | (ln << 5) | (db << 3) | dp);
   endfunction

   function automatic logic [11:0] mkx(input int sb, input int sp, input int ln, input int imm);
      return 12'((sb << 11) | (sp << 8) | (ln << 5) | (imm & 31));
   endfunction

   // one operation: drive at negedge, model at posedge, compare at next negedge
   task automatic do_op(input bit v, input int kind, input logic [11:0] ins,
                        input int val, input int la, input int ra, input int rd);
      int len, msk, bank, pos, k, rot, sh, pm, pv, merged, data, addr;
      string tf, tw;
      op_valid = v; op_kind = 2'(kind); instr = ins; ins_value = 8'(val);
      left_addr = AW'(la); right_addr = AW'(ra); port_rdata = 8'(rd);
      len = (int'(ins) >> 5) & 7;
      if (len == 0) len = 8;
      msk = (1 << len) - 1;
      bank = (kind == 1) ? ((int'(ins) >> 3) & 1) : ((int'(ins) >> 11) & 1);
      pos  = (kind == 1) ? (int'(ins) & 7) : ((int'(ins) >> 8) & 7);
      addr = bank ? (ra + 256) : la;
      tf = "R10"; tw = "R10";
      #1;
      if (v && kind != 3) chk("R7", "port_raddr", int'(port_raddr), addr);
      @(posedge clk);
      m_wr = 0;
      if (v && kind == 0) begin
         k = 7 - pos;
         rot = ((rd >> k) | (rd << (8 - k))) & 255;
         m_field = rot & msk;
         if (bank) m_right = rd; else m_left = rd;
         tf = (len == 8) ? "R2" : "R3"; tw = "R9";
      end else if (v && (kind == 1 || kind == 2)) begin
         sh = 7 - pos;
         data = (kind == 2) ? (int'(ins) & 31) : val;
         pm = (msk << sh) & 255;
         pv = (data << sh) & 255;
         merged = (rd & ~pm & 255) | (pv & pm);
         m_wr = 1; m_wdata = merged; m_waddr = addr;
         if (bank) m_right = merged; else m_left = merged;
         tf = "R9"; tw = (kind == 2) ? "R8" : ((len == 8) ? "R2" : "R4");
      end
      @(negedge clk);
      chk_all(tf, tw, (m_wr != 0) ? "R7" : tw);
      if (v && (kind == 1 || kind == 2)) begin
         chk("R5", "preserved bits", int'(port_wdata) & ~pm & 255, rd & ~pm & 255);
         chk("R6", "latch equals written byte",
             bank ? int'(right_vec) : int'(left_vec), int'(port_wdata));
      end
   endtask

   initial begin
      #40000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      m_field = 0; m_wr = 0; m_waddr = 0; m_wdata = 0; m_left = 0; m_right = 0;
      repeat (3) @(negedge clk);
      chk_all("R1", "R1", "R1");                       // R1 during reset
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk_all("R1", "R1", "R1");                       // R1 after release

      // R2: length code 0, position 7 -> whole byte
      do_op(1, 0, mk(0, 7, 0, 0, 0), 0, 8'h12, 8'h34, 8'hA5);
      // R3: wrap-around at position 0, length 3, right bank
      do_op(1, 0, mk(1, 0, 3, 0, 0), 0, 8'h12, 8'h34, 8'h81);
      do_op(1, 0, mk(0, 3, 4, 0, 0), 0, 8'h55, 8'h66, 8'h3C);
      // R4: insert left, position 7 length 4
      do_op(1, 1, mk(0, 0, 4, 0, 7), 8'hFF, 8'h20, 8'h40, 8'h00);
      // R4: truncation at position 0, right bank
      do_op(1, 1, mk(0, 0, 3, 1, 0), 8'h07, 8'h20, 8'h40, 8'h00);
      // R5: preservation of ones around a cleared field
      do_op(1, 1, mk(0, 0, 2, 0, 3), 8'h00, 8'h21, 8'h41, 8'hFF);
      // R2: insert with full-byte length
      do_op(1, 1, mk(0, 0, 0, 1, 7), 8'hC3, 8'h22, 8'hFE, 8'h18);
      // R8: transmit literal, ins_value must be ignored
      do_op(1, 2, mkx(1, 5, 5, 31), 8'h00, 8'h10, 8'h11, 8'h00);
      do_op(1, 2, mkx(0, 7, 0, 5), 8'hAA, 8'h10, 8'h11, 8'hF0);
      // R10: reserved kind and idle cycles
      do_op(1, 3, mk(1, 2, 3, 1, 2), 8'hFF, 8'h01, 8'h02, 8'h77);
      do_op(0, 1, mk(0, 1, 4, 0, 1), 8'hFF, 8'h01, 8'h02, 8'h77);
      do_op(0, 0, mk(1, 1, 4, 1, 1), 8'hFF, 8'h01, 8'h02, 8'h99);

      for (int n = 0; n < 400; n++) begin
         do_op(($urandom % 5) != 0, int'($urandom % 4), 12'($urandom),
               int'($urandom % 256), int'($urandom % 256),
               int'($urandom % 256), int'($urandom % 256));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule